// File: doc/BRIEF.md
# Pattern Recognizer for the Symbol Run a-b-b-a

This block watches a stream of symbols taken from a three-letter alphabet {a, b, c}. Each symbol arrives on a 2-bit bus, one per clock, and is marked by a valid strobe. A synchronous Moore state machine tracks how much of the run a, b, b, a has been seen so far. When the final `a` completes the run, the machine enters an accept state. A one-bit match output is decoded from that state alone. The current state code is also brought out so that the surrounding logic can observe progress.

On a symbol that breaks the run, the machine falls back to the longest start of the pattern that is still valid. It does not simply clear. Because of this, overlapping occurrences are found: in the stream a b b a b b a, the match is reported twice. The symbol c and the unused code 11 both clear any partial progress. The five states are:

- idle: nothing seen.
- seen_a: the first `a` has arrived.
- seen_ab: `a b` has arrived.
- seen_abb: `a b b` has arrived.
- accept: the whole run has arrived.

The transitions are advance, fall back to seen_a, fall back to idle, overlap to seen_ab, and hold.

Top module: `abba_recognizer`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state becomes idle (code 0) and `match` becomes 0, whatever the other inputs are.
- R2: The state codes on `state_code` are: idle = 0, seen_a = 1, seen_ab = 2, seen_abb = 3, accept = 4. The symbol codes are: a = 00, b = 01. A valid b taken in seen_a moves the state to seen_ab, and a valid b taken in seen_ab moves it to seen_abb.
- R3: A valid a (00) taken in seen_abb moves the state to accept. `match` is 1 exactly while the state is accept, so it goes high on the clock edge that takes the final a.
- R4: While `sym_valid` is low, the state and `match` do not change at a clock edge.
- R5: A valid a (00) taken in idle, seen_a, seen_ab or accept moves the state to seen_a.
- R6: A valid b (01) taken in idle leaves the state idle. A valid b taken in seen_abb moves it to idle.
- R7: A valid b (01) taken in accept moves the state to seen_ab, so that overlapping runs are detected.
- R8: A valid c (10) taken in any state moves the state to idle.
- R9: A valid illegal code 11 taken in any state moves the state to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | High when `sym` carries a symbol this cycle |
| sym | input | 2 | Symbol code: a=00, b=01, c=10, 11 illegal |
| match | output | 1 | High while the machine is in accept |
| state_code | output | 3 | Current state code (0 to 4) |

## Verification
Every result of this block is due one clock edge after the symbol that causes it. Inputs are driven 1 ns after a rising edge. The state code and `match` are compared 1 ns after the next rising edge, against a bench reference model that has taken that same symbol. Because `match` is a Moore output, it is compared in the same sample as the state that produces it. A held (invalid) cycle is compared the same way, and must show an unchanged state.

// File: rtl/abba_pkg.sv
package abba_pkg;

    parameter int SYM_W   = 2;
    parameter int N_STATE = 5;
    localparam int STATE_W = $clog2(N_STATE);

    localparam logic [SYM_W-1:0] CODE_A   = 2'b00;
    localparam logic [SYM_W-1:0] CODE_B   = 2'b01;
    localparam logic [SYM_W-1:0] CODE_C   = 2'b10;
    localparam logic [SYM_W-1:0] CODE_BAD = 2'b11;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE     = 3'd0,
        ST_SEEN_A   = 3'd1,
        ST_SEEN_AB  = 3'd2,
        ST_SEEN_ABB = 3'd3,
        ST_ACCEPT   = 3'd4
    } rec_state_e;

    typedef enum logic [1:0] {
        K_A,
        K_B,
        K_C,
        K_BAD
    } sym_kind_e;

endpackage

// File: rtl/abba_sym_classify.sv
module abba_sym_classify
    import abba_pkg::*;
(
    input  logic [SYM_W-1:0] sym,
    output sym_kind_e        kind
);

    always_comb begin
        unique case (sym)
            CODE_A:  kind = K_A;
            CODE_B:  kind = K_B;
            CODE_C:  kind = K_C;
            default: kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/abba_next_state.sv
module abba_next_state
    import abba_pkg::*;
(
    input  rec_state_e cur,
    input  logic       take,
    input  sym_kind_e  kind,
    output rec_state_e nxt
);

    // Transition function: advance, fall back to seen_a, fall back to idle,
    // overlap to seen_ab, or hold while no symbol is taken.
    always_comb begin
        nxt = cur;
        if (take) begin
            unique case (kind)
                K_A: begin
                    unique case (cur)
                        ST_SEEN_ABB: nxt = ST_ACCEPT;
                        default:     nxt = ST_SEEN_A;
                    endcase
                end
                K_B: begin
                    unique case (cur)
                        ST_SEEN_A:   nxt = ST_SEEN_AB;
                        ST_SEEN_AB:  nxt = ST_SEEN_ABB;
                        ST_ACCEPT:   nxt = ST_SEEN_AB;
                        default:     nxt = ST_IDLE;
                    endcase
                end
                K_C:     nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/abba_state_reg.sv
module abba_state_reg
    import abba_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rec_state_e nxt,
    output rec_state_e cur
);

    always_ff @(posedge clk) begin
        if (rst) cur <= ST_IDLE;
        else     cur <= nxt;
    end

endmodule

// File: rtl/abba_out_decode.sv
module abba_out_decode
    import abba_pkg::*;
(
    input  rec_state_e         cur,
    output logic               match,
    output logic [STATE_W-1:0] state_code
);

    always_comb begin
        state_code = cur;
        unique case (cur)
            ST_ACCEPT: match = 1'b1;
            default:   match = 1'b0;
        endcase
    end

endmodule

// File: rtl/abba_recognizer.sv
module abba_recognizer
    import abba_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sym_valid,
    input  logic [SYM_W-1:0]   sym,
    output logic               match,
    output logic [STATE_W-1:0] state_code
);

    sym_kind_e  kind;
    rec_state_e cur;
    rec_state_e nxt;

    abba_sym_classify u_cls (
        .sym  (sym),
        .kind (kind)
    );

    abba_next_state u_nxt (
        .cur  (cur),
        .take (sym_valid),
        .kind (kind),
        .nxt  (nxt)
    );

    abba_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .cur (cur)
    );

    abba_out_decode u_out (
        .cur        (cur),
        .match      (match),
        .state_code (state_code)
    );

endmodule

// File: rtl/abba_recognizer_chk.sv
module abba_recognizer_chk
    import abba_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               sym_valid,
    input logic [SYM_W-1:0]   sym,
    input logic               match,
    input logic [STATE_W-1:0] state_code
);

    logic seen_edge;
    always_ff @(posedge clk) seen_edge <= 1'b1;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (state_code == 3'd0 && !match));

    p_state_legal_r2: assert property (@(posedge clk) disable iff (rst || !seen_edge)
        state_code <= 3'd4);

    p_b_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym == CODE_B && state_code == 3'd1) |=> state_code == 3'd2);

    p_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym == CODE_A && state_code == 3'd3) |=> match);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> $stable(state_code));

    p_fallback_a_r5: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym == CODE_A && state_code != 3'd3) |=> state_code == 3'd1);

    p_b_from_abb_r6: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym == CODE_B && state_code == 3'd3) |=> state_code == 3'd0);

    p_overlap_r7: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym == CODE_B && state_code == 3'd4) |=> state_code == 3'd2);

    p_c_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym == CODE_C) |=> state_code == 3'd0);

    p_bad_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym == CODE_BAD) |=> state_code == 3'd0);

endmodule

bind abba_recognizer abba_recognizer_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .sym_valid  (sym_valid),
    .sym        (sym),
    .match      (match),
    .state_code (state_code)
);

// File: tb/abba_recognizer_tb_top.sv
`timescale 1ns/1ps
module abba_recognizer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic [1:0] sym = 2'b00;
    logic       match;
    logic [2:0] state_code;

    int checks = 0;
    int errors = 0;
    int ms = 0;

    always #2.5 clk = ~clk;

    abba_recognizer dut_i (
        .clk        (clk),
        .rst        (rst),
        .sym_valid  (sym_valid),
        .sym        (sym),
        .match      (match),
        .state_code (state_code)
    );

    function automatic int ref_next(int s, logic v, logic [1:0] x);
        if (!v) return s;
        case (x)
            2'b00:   return (s == 3) ? 4 : 1;
            2'b01:   return (s == 1) ? 2 : (s == 2) ? 3 : (s == 4) ? 2 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_for(int s, logic v, logic [1:0] x);
        if (!v) return "R4";
        if (x == 2'b11) return "R9";
        if (x == 2'b10) return "R8";
        if (x == 2'b00) return (s == 3) ? "R3" : "R5";
        if (s == 4) return "R7";
        if (s == 0 || s == 3) return "R6";
        return "R2";
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] x);
        string tag;
        int    exp;
        sym_valid = v;
        sym       = x;
        tag = tag_for(ms, v, x);
        exp = ref_next(ms, v, x);
        @(posedge clk); #1;
        ms = exp;
        chk(state_code == exp[2:0], tag, state_code, exp);
        chk(match == (exp == 4), "R3", match, (exp == 4));
    endtask

    task automatic do_reset(input logic v, input logic [1:0] x);
        rst = 1'b1; sym_valid = v; sym = x;
        @(posedge clk); #1;
        rst = 1'b0;
        ms = 0;
        chk(state_code == 3'd0, "R1", state_code, 0);
        chk(match == 1'b0, "R1", match, 0);
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0ABB));
        @(posedge clk); #1;
        do_reset(1'b0, 2'b00);
        // R2 R3 straight run a b b a
        step(1, 2'b00); step(1, 2'b01); step(1, 2'b01); step(1, 2'b00);
        // R4 hold in accept
        step(0, 2'b01); step(0, 2'b10);
        // R7 overlap: b b a again
        step(1, 2'b01); step(1, 2'b01); step(1, 2'b00);
        // R5 fallback from accept, seen_a, seen_ab
        step(1, 2'b00); step(1, 2'b00); step(1, 2'b01); step(1, 2'b00);
        // R6 b in idle and after abb
        do_reset(1, 2'b00);
        step(1, 2'b01);
        step(1, 2'b00); step(1, 2'b01); step(1, 2'b01); step(1, 2'b01);
        // R8 c from each state
        step(1, 2'b00); step(1, 2'b01); step(1, 2'b10);
        step(1, 2'b00); step(1, 2'b01); step(1, 2'b01); step(1, 2'b10);
        // R9 illegal code mid-run and from accept
        step(1, 2'b00); step(1, 2'b01); step(1, 2'b11);
        step(1, 2'b00); step(1, 2'b01); step(1, 2'b01); step(1, 2'b00); step(1, 2'b11);
        // R1 reset wins over a valid completing symbol
        step(1, 2'b00); step(1, 2'b01); step(1, 2'b01);
        do_reset(1, 2'b00);
        // random stream biased toward a and b
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [1:0] x;
            r = $urandom % 16;
            x = (r < 7) ? 2'b00 : (r < 13) ? 2'b01 : (r < 15) ? 2'b10 : 2'b11;
            if ($urandom % 300 == 0) do_reset(1, x);
            else step(($urandom % 4) != 0, x);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule